// File: doc/BRIEF.md
# Sticky Interrupt Status Register Bank

This block gathers the event strobes and level conditions of a quad-SPI flash controller into one 32-bit interrupt status word. Error and completion events are latched into sticky bits. These include a transmit transfer attempted on an empty FIFO, a receive push into a full FIFO, an indirect request refused because the pending queue is full, a refused protected write, an illegal bus burst or response, an indirect watermark, and an SRAM partition running full. The sticky bits stay set until software reads the word.

Four further bits reflect the present fill state of the transmit and receive FIFOs. They are recomputed every cycle and a read does not touch them. A small internal counter tracks how many indirect operations are pending, up to two, so that a third request can be flagged as refused. A single-strobe read port returns the word as it stood before the read, and the sticky bits are cleared on the same edge. A registered interrupt line goes high when any status bit selected by a mask input is set.

Top module: `irq_status_bank`

## Requirements
- R1: After synchronous reset the status word is 0x0000_0100: bit 8 is 1 and every other bit is 0. Both `rd_data` and `irq` are 0.
- R2: Bit 1 (underflow) is set on the clock edge where `tx_pop` and `tx_empty` are both high. `tx_pop` alone does not set it.
- R3: Bit 7 (receive overflow) is set on the clock edge where `rx_push` and `rx_full` are both high.
- R4: The sticky bits are 1–7 and 12. Each keeps its value until a read. A read with `rd_en` high returns the value before the clear in `rd_data`, and clears the bit on the same edge.
- R5: When a sticky bit's set event and a read fall in the same cycle, the bit stays 1 after that edge.
- R6: At most two indirect operations are pending. A request (`ind_req`) made while two are pending sets bit 3 and is not counted. A completion (`ind_done`) in the same cycle frees a slot, so that request is accepted. Each completion sets bit 2.
- R7: Bit 4 is set by `prot_wr_reject`. Bit 5 is set by `bus_wrap_burst` or by `bus_split_retry`. Bit 6 is set by `ind_wmark`. Bit 12 is set by `sram_part_full`.
- R8: Bits 8–11 are registered live comparisons and are not cleared by a read. Bit 8 is `tx_level <= tx_thresh`. Bit 9 is `tx_level == FIFO_DEPTH`. Bit 10 is `rx_level >= rx_thresh`. Bit 11 is `rx_level == FIFO_DEPTH`.
- R9: Bit 0 and bits 31:13 always read as 0.
- R10: `irq` is the OR over (status & `irq_mask`), registered. It follows the status word one cycle later.
- R11: `rd_data` changes only on a read and holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe: captures the status word and clears the sticky bits |
| rd_data | output | 32 | Status word captured at the last read |
| irq_mask | input | 32 | Per-bit interrupt enable |
| irq | output | 1 | Registered combined interrupt |
| tx_pop | input | 1 | Transmit transfer attempt |
| tx_empty | input | 1 | Transmit FIFO empty flag |
| rx_push | input | 1 | Receive FIFO push attempt |
| rx_full | input | 1 | Receive FIFO full flag |
| tx_level | input | LVL_W | Transmit FIFO fill count |
| tx_thresh | input | LVL_W | Transmit threshold |
| rx_level | input | LVL_W | Receive FIFO fill count |
| rx_thresh | input | LVL_W | Receive threshold |
| ind_req | input | 1 | Indirect operation request |
| ind_done | input | 1 | Indirect operation completed |
| ind_wmark | input | 1 | Indirect transfer watermark reached |
| sram_part_full | input | 1 | Indirect SRAM partition full |
| prot_wr_reject | input | 1 | Write to a protected area refused |
| bus_wrap_burst | input | 1 | Wrapping burst seen on the bus |
| bus_split_retry | input | 1 | SPLIT or RETRY response seen on the bus |

## Verification
The bench builds the block with `FIFO_DEPTH` = 4, which makes the level inputs 3 bits wide. At that size, full FIFOs and threshold crossings on both sides can be set up directly, so the full-flag bits 9 and 11 are reached with small counts. The pending-queue limit stays at its default of two, which puts the refused-request path and the same-cycle completion case within three requests.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int STAT_W = 32;

    localparam int B_UNDERFLOW  = 1;
    localparam int B_IND_DONE   = 2;
    localparam int B_IND_REJECT = 3;
    localparam int B_PROT_WR    = 4;
    localparam int B_BUS_ERR    = 5;
    localparam int B_IND_WMARK  = 6;
    localparam int B_RX_OVER    = 7;
    localparam int B_TX_THR     = 8;
    localparam int B_TX_FULL    = 9;
    localparam int B_RX_THR     = 10;
    localparam int B_RX_FULL    = 11;
    localparam int B_SRAM_FULL  = 12;

    // Field order matches bit positions 12 down to 1.
    typedef struct packed {
        logic sram_full;
        logic rx_full;
        logic rx_thr;
        logic tx_full;
        logic tx_thr;
        logic rx_over;
        logic ind_wmark;
        logic bus_err;
        logic prot_wr;
        logic ind_reject;
        logic ind_done;
        logic underflow;
    } flags_t;

    localparam logic [STAT_W-1:0] STICKY_MASK = 32'h0000_10FE;
    localparam logic [STAT_W-1:0] LEVEL_MASK  = 32'h0000_0F00;
    localparam logic [STAT_W-1:0] RESET_VAL   = 32'h0000_0100;

    function automatic logic [STAT_W-1:0] to_word(input flags_t f);
        return {{(STAT_W - $bits(flags_t) - 1){1'b0}}, f, 1'b0};
    endfunction

endpackage

// File: rtl/irq_event_detect.sv
module irq_event_detect
    import irq_bank_pkg::*;
(
    input  logic   tx_pop,
    input  logic   tx_empty,
    input  logic   rx_push,
    input  logic   rx_full,
    input  logic   ind_done,
    input  logic   ind_reject,
    input  logic   ind_wmark,
    input  logic   sram_part_full,
    input  logic   prot_wr_reject,
    input  logic   bus_wrap_burst,
    input  logic   bus_split_retry,
    output flags_t ev
);
    always_comb begin
        ev            = '0;
        ev.underflow  = tx_pop & tx_empty;
        ev.rx_over    = rx_push & rx_full;
        ev.ind_done   = ind_done;
        ev.ind_reject = ind_reject;
        ev.ind_wmark  = ind_wmark;
        ev.sram_full  = sram_part_full;
        ev.prot_wr    = prot_wr_reject;
        ev.bus_err    = bus_wrap_burst | bus_split_retry;
    end
endmodule

// File: rtl/irq_ind_queue.sv
module irq_ind_queue #(
    parameter int PEND_MAX = 2,
    localparam int CW = $clog2(PEND_MAX + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic done,
    output logic reject
);
    logic [CW-1:0] cnt_q;
    logic          accept;
    logic          retire;

    assign reject = req & (cnt_q == CW'(PEND_MAX)) & ~done;
    assign accept = req & ~reject;
    assign retire = done & (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (accept && !retire) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (retire && !accept) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/irq_level_cmp.sv
module irq_level_cmp
    import irq_bank_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] tx_thresh,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_thresh,
    output flags_t           lvl
);
    localparam logic [LVL_W-1:0] FULL_CNT = LVL_W'(FIFO_DEPTH);

    always_comb begin
        lvl         = '0;
        lvl.tx_thr  = (tx_level <= tx_thresh);
        lvl.tx_full = (tx_level == FULL_CNT);
        lvl.rx_thr  = (rx_level >= rx_thresh);
        lvl.rx_full = (rx_level == FULL_CNT);
    end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_bank_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int PEND_MAX   = 2,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    input  logic [31:0]       irq_mask,
    output logic              irq,
    input  logic              tx_pop,
    input  logic              tx_empty,
    input  logic              rx_push,
    input  logic              rx_full,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  tx_thresh,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  rx_thresh,
    input  logic              ind_req,
    input  logic              ind_done,
    input  logic              ind_wmark,
    input  logic              sram_part_full,
    input  logic              prot_wr_reject,
    input  logic              bus_wrap_burst,
    input  logic              bus_split_retry
);
    flags_t            ev_f;
    flags_t            lvl_f;
    logic              ind_reject;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] lvl_vec;
    logic [STAT_W-1:0] stat_d;
    logic [STAT_W-1:0] stat_q;

    irq_ind_queue #(.PEND_MAX(PEND_MAX)) u_queue (
        .clk    (clk),
        .rst    (rst),
        .req    (ind_req),
        .done   (ind_done),
        .reject (ind_reject)
    );

    irq_event_detect u_detect (
        .tx_pop          (tx_pop),
        .tx_empty        (tx_empty),
        .rx_push         (rx_push),
        .rx_full         (rx_full),
        .ind_done        (ind_done),
        .ind_reject      (ind_reject),
        .ind_wmark       (ind_wmark),
        .sram_part_full  (sram_part_full),
        .prot_wr_reject  (prot_wr_reject),
        .bus_wrap_burst  (bus_wrap_burst),
        .bus_split_retry (bus_split_retry),
        .ev              (ev_f)
    );

    irq_level_cmp #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_level (
        .tx_level  (tx_level),
        .tx_thresh (tx_thresh),
        .rx_level  (rx_level),
        .rx_thresh (rx_thresh),
        .lvl       (lvl_f)
    );

    assign set_vec = to_word(ev_f);
    assign lvl_vec = to_word(lvl_f);

    // Per-bit next state chosen by the bit's class.
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (STICKY_MASK[i]) begin : g_sticky
            assign stat_d[i] = set_vec[i] | (stat_q[i] & ~rd_en);
        end else if (LEVEL_MASK[i]) begin : g_level
            assign stat_d[i] = lvl_vec[i];
        end else begin : g_rsvd
            assign stat_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= RESET_VAL;
            rd_data <= '0;
            irq     <= 1'b0;
        end else begin
            stat_q <= stat_d;
            irq    <= |(stat_q & irq_mask);
            if (rd_en) begin
                rd_data <= stat_q;
            end
        end
    end
endmodule

// File: rtl/irq_status_bank_chk.sv
module irq_status_bank_chk (
    input logic        clk,
    input logic        rst,
    input logic        rd_en,
    input logic [31:0] rd_data,
    input logic [31:0] irq_mask,
    input logic        irq,
    input logic [31:0] stat_q,
    input logic        tx_pop,
    input logic        tx_empty,
    input logic        rx_push,
    input logic        rx_full
);
    // R2
    underflow_set_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_pop && tx_empty) |=> stat_q[1]);

    // R3
    rx_over_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_full) |=> stat_q[7]);

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_q[1] && !rd_en) |=> stat_q[1]);

    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !(rx_push && rx_full)) |=> !stat_q[7]);

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rx_push && rx_full) |=> stat_q[7]);

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data[0] == 1'b0) && (rd_data[31:13] == '0));

    // R10
    irq_low_chk: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & irq_mask) == '0) |=> !irq);

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
endmodule

bind irq_status_bank irq_status_bank_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .irq_mask (irq_mask),
    .irq      (irq),
    .stat_q   (stat_q),
    .tx_pop   (tx_pop),
    .tx_empty (tx_empty),
    .rx_push  (rx_push),
    .rx_full  (rx_full)
);

// File: tb/sim_irq_status_bank.sv
module sim_irq_status_bank;
    localparam int DEPTH = 4;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_en = 1'b0;
    logic [31:0]   rd_data;
    logic [31:0]   irq_mask = '0;
    logic          irq;
    logic          tx_pop = 1'b0, tx_empty = 1'b0, rx_push = 1'b0, rx_full = 1'b0;
    logic [LW-1:0] tx_level = '0, tx_thresh = LW'(1), rx_level = '0, rx_thresh = LW'(2);
    logic          ind_req = 1'b0, ind_done = 1'b0, ind_wmark = 1'b0, sram_part_full = 1'b0;
    logic          prot_wr_reject = 1'b0, bus_wrap_burst = 1'b0, bus_split_retry = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_status_bank #(.FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_data(rd_data),
        .irq_mask(irq_mask), .irq(irq),
        .tx_pop(tx_pop), .tx_empty(tx_empty), .rx_push(rx_push), .rx_full(rx_full),
        .tx_level(tx_level), .tx_thresh(tx_thresh), .rx_level(rx_level), .rx_thresh(rx_thresh),
        .ind_req(ind_req), .ind_done(ind_done), .ind_wmark(ind_wmark),
        .sram_part_full(sram_part_full), .prot_wr_reject(prot_wr_reject),
        .bus_wrap_burst(bus_wrap_burst), .bus_split_retry(bus_split_retry)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_read(output logic [31:0] v);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 rd_data after reset", rd_data, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        do_read(v);
        chk("R1 reset status word", v, 32'h0000_0100);
    endtask

    task automatic t_underflow();
        logic [31:0] v;
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
        do_read(v);
        chk("R2 pop without empty ignored", v, 32'h0000_0100);
        tx_pop = 1'b1; tx_empty = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0; tx_empty = 1'b0;
        do_read(v);
        chk("R2 underflow set", v, 32'h0000_0102);
        do_read(v);
        chk("R4 underflow cleared by read", v, 32'h0000_0100);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        rx_push = 1'b1; rx_full = 1'b1;
        @(negedge clk);
        rx_push = 1'b0; rx_full = 1'b0;
        idle(3);
        do_read(v);
        chk("R3 R4 overflow set and held", v, 32'h0000_0180);
        idle(2);
        chk("R11 rd_data holds between reads", rd_data, 32'h0000_0180);
        do_read(v);
        chk("R4 overflow cleared by read", v, 32'h0000_0100);
    endtask

    task automatic t_coincident();
        logic [31:0] v;
        rx_push = 1'b1; rx_full = 1'b1;
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; rx_push = 1'b0; rx_full = 1'b0;
        chk("R5 read returns pre-clear word", rd_data, 32'h0000_0180);
        do_read(v);
        chk("R5 set wins over clear", v, 32'h0000_0180);
        do_read(v);
        chk("R5 later read clears", v, 32'h0000_0100);
    endtask

    task automatic t_indirect();
        logic [31:0] v;
        ind_req = 1'b1;
        idle(2);
        @(negedge clk);
        ind_req = 1'b0;
        do_read(v);
        chk("R6 third request refused", v, 32'h0000_0108);
        ind_req = 1'b1; ind_done = 1'b1;
        @(negedge clk);
        ind_req = 1'b0; ind_done = 1'b0;
        do_read(v);
        chk("R6 completion frees slot, done flagged", v, 32'h0000_0104);
        ind_req = 1'b1;
        @(negedge clk);
        ind_req = 1'b0;
        do_read(v);
        chk("R6 queue still full after swap", v, 32'h0000_0108);
        ind_done = 1'b1;
        idle(2);
        ind_done = 1'b0;
        do_read(v);
        chk("R6 completions flag done", v, 32'h0000_0104);
        ind_req = 1'b1;
        idle(2);
        ind_req = 1'b0;
        do_read(v);
        chk("R6 two requests accepted on empty queue", v, 32'h0000_0100);
        ind_done = 1'b1;
        idle(2);
        ind_done = 1'b0;
        do_read(v);
    endtask

    task automatic t_misc();
        logic [31:0] v;
        prot_wr_reject = 1'b1; ind_wmark = 1'b1; sram_part_full = 1'b1; bus_wrap_burst = 1'b1;
        @(negedge clk);
        prot_wr_reject = 1'b0; ind_wmark = 1'b0; sram_part_full = 1'b0; bus_wrap_burst = 1'b0;
        do_read(v);
        chk("R7 protect, watermark, sram, wrap", v, 32'h0000_1170);
        bus_split_retry = 1'b1;
        @(negedge clk);
        bus_split_retry = 1'b0;
        do_read(v);
        chk("R7 split/retry sets bus error", v, 32'h0000_0120);
        do_read(v);
        chk("R9 reserved bits zero", v & 32'hFFFF_E001, 32'h0);
    endtask

    task automatic t_levels();
        logic [31:0] v;
        tx_level = LW'(DEPTH); rx_level = LW'(DEPTH);
        @(negedge clk);
        do_read(v);
        chk("R8 full and threshold levels", v, 32'h0000_0E00);
        do_read(v);
        chk("R8 level bits not cleared by read", v, 32'h0000_0E00);
        tx_level = LW'(1); rx_level = LW'(1);
        @(negedge clk);
        do_read(v);
        chk("R8 tx at threshold, rx below", v, 32'h0000_0100);
        tx_level = '0;
    endtask

    task automatic t_irq();
        logic [31:0] v;
        irq_mask = 32'h0000_0080;
        @(negedge clk);
        chk("R10 masked-off level bit gives no irq", {31'b0, irq}, 32'h0);
        rx_push = 1'b1; rx_full = 1'b1;
        @(negedge clk);
        rx_push = 1'b0; rx_full = 1'b0;
        chk("R10 irq one cycle after status", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R10 irq raised", {31'b0, irq}, 32'h1);
        irq_mask = 32'h0;
        @(negedge clk);
        chk("R10 irq follows mask", {31'b0, irq}, 32'h0);
        irq_mask = 32'h0000_0100;
        @(negedge clk);
        chk("R10 irq from live level bit", {31'b0, irq}, 32'h1);
        irq_mask = 32'h0000_0080;
        do_read(v);
        @(negedge clk);
        chk("R10 irq drops after clear", {31'b0, irq}, 32'h0);
        irq_mask = 32'h0;
    endtask

    initial begin
        #(8 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_underflow();
        t_overflow();
        t_coincident();
        t_indirect();
        t_misc();
        t_levels();
        t_irq();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule